// File: doc/BRIEF.md
# Store Retirement Ring

This block holds the stores of one thread of an out-of-order core, from dispatch until memory has accepted their writes. Dispatch claims the slot at the tail of a circular array. Execute later fills in the address, byte count and up to sixteen data bytes. A commit request makes every store older than a given sequence number eligible to leave. A squash request removes every store younger than a given sequence number.

A separate drain pointer walks forward in program order. It presents each eligible store to a valid/ready memory write port. A store that has been accepted is marked done. The head pointer then frees done slots one per cycle. Commit therefore never frees a slot by itself. One slot of the array is always held empty, so the usable depth is one less than the array size. The block reports the free-slot count and the number of eligible stores not yet sent as registered outputs. It also reports a full flag and a flag that is high when a write is accepted in the current cycle.

Top module: `sq_ring`

## Requirements
- R1: After reset, `free_cnt` equals SLOTS-1, `full` and `mem_req_valid` are low and `wb_pend` is zero.
- R2: Each accepted allocation lowers `free_cnt` by one on the next clock edge. `full` is high exactly when `free_cnt` is zero, which happens with SLOTS-1 stores held. An allocation request while `full` is high, or in the same cycle as a squash, is ignored and leaves `free_cnt` unchanged.
- R3: A commit with sequence number C marks every held store whose sequence number is below C (unsigned compare) as eligible. `wb_pend` rises by the number of stores newly marked. A store that was never marked is never presented on the memory port.
- R4: Eligible stores are presented on the memory port strictly in allocation order. Each request carries the address, size and data last written by the fill port for that slot, and at most one request is accepted per cycle.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with unchanged address, size and data on the next cycle.
- R6: A slot is released only after its write is accepted. `free_cnt` rises one cycle after the accepting edge and does not change on commit.
- R7: A squash with sequence number S removes every held store whose sequence number exceeds S. `free_cnt` rises by that number, and the next allocation reuses the oldest removed slot index.
- R8: `will_wb` is high exactly in the cycles where the memory port accepts a request, and `wb_pend` falls by one at each such edge.
- R9: Slot indices advance modulo SLOTS. After the last index, the next allocation index given on `alloc_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Claim the tail slot for a new store |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_idx | output | IW | Slot index the next allocation will take |
| full | output | 1 | No slot can be claimed |
| fill_valid | input | 1 | Write address, size and data into a slot |
| fill_idx | input | IW | Slot to fill |
| fill_addr | input | ADDR_W | Store address |
| fill_size | input | SW | Byte count, 0 to DBYTES |
| fill_data | input | 8*DBYTES | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Stores older than this become eligible |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| mem_req_valid | output | 1 | Write request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_size | output | SW | Request byte count |
| mem_req_data | output | 8*DBYTES | Request data |
| will_wb | output | 1 | A write is accepted this cycle |
| free_cnt | output | IW+1 | Registered free-slot count |
| wb_pend | output | IW+1 | Registered count of eligible, unsent stores |

## Verification
The bench builds the ring with SLOTS=4, which leaves three usable slots. With that size, the full condition, the ignored allocation and index wrap-around all occur within a dozen stores. Sequence numbers are eight bits wide. Address and data are fixed patterns, so any swap in drain order shows up in the scoreboard. Stalls come from holding ready low for several cycles and then toggling it, which exercises both the hold rule and release one cycle after acceptance.

// File: rtl/sq_ring.sv
module sq_ring #(
  parameter int SLOTS  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DBYTES = 16,
  localparam int IW = $clog2(SLOTS),
  localparam int CW = IW + 1,
  localparam int SW = $clog2(DBYTES + 1),
  localparam int DW = 8 * DBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IW-1:0]     alloc_idx,
  output logic              full,
  input  logic              fill_valid,
  input  logic [IW-1:0]     fill_idx,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [SW-1:0]     fill_size,
  input  logic [DW-1:0]     fill_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [SW-1:0]     mem_req_size,
  output logic [DW-1:0]     mem_req_data,
  output logic              will_wb,
  output logic [CW-1:0]     free_cnt,
  output logic [CW-1:0]     wb_pend
);

  logic [SEQ_W-1:0]  seq_q  [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [SW-1:0]     size_q [SLOTS];
  logic [DW-1:0]     data_q [SLOTS];
  logic [SLOTS-1:0]  vld, can_wb, cmt, done;
  logic [IW-1:0]     head, wbp, tail;
  logic [SLOTS-1:0]  sq_mask, cm_mask;
  logic [CW-1:0]     n_sq, n_cm;
  logic              alloc_fire, rel, hs;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (int'(i) == SLOTS - 1) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IW-1:0] back(input logic [IW-1:0] i, input logic [CW-1:0] n);
    int t;
    t = int'(i) - int'(n);
    if (t < 0) t = t + SLOTS;
    return IW'(t);
  endfunction

  always_comb begin
    n_sq = '0;
    n_cm = '0;
    for (int i = 0; i < SLOTS; i++) begin
      sq_mask[i] = squash_valid && vld[i] && (seq_q[i] > squash_seq);
      cm_mask[i] = commit_valid && vld[i] && !can_wb[i] && !sq_mask[i] && (seq_q[i] < commit_seq);
      n_sq = n_sq + CW'(sq_mask[i]);
      n_cm = n_cm + CW'(cm_mask[i]);
    end
  end

  assign full          = (free_cnt == '0);
  assign alloc_idx     = tail;
  assign alloc_fire    = alloc_valid && !full && !squash_valid;
  assign rel           = vld[head] && done[head];
  assign mem_req_valid = vld[wbp] && can_wb[wbp] && !done[wbp];
  assign mem_req_addr  = addr_q[wbp];
  assign mem_req_size  = size_q[wbp];
  assign mem_req_data  = data_q[wbp];
  assign hs            = mem_req_valid && mem_req_ready;
  assign will_wb       = hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; can_wb <= '0; cmt <= '0; done <= '0;
      head <= '0; wbp <= '0; tail <= '0;
      free_cnt <= CW'(SLOTS - 1);
      wb_pend  <= '0;
    end else begin
      if (squash_valid) begin
        tail <= back(tail, n_sq);
        for (int i = 0; i < SLOTS; i++)
          if (sq_mask[i]) vld[i] <= 1'b0;
      end else if (alloc_fire) begin
        vld[tail]    <= 1'b1;
        can_wb[tail] <= 1'b0;
        cmt[tail]    <= 1'b0;
        done[tail]   <= 1'b0;
        tail         <= step(tail);
      end
      for (int i = 0; i < SLOTS; i++)
        if (cm_mask[i]) begin
          cmt[i]    <= 1'b1;
          can_wb[i] <= 1'b1;
        end
      if (hs) begin
        done[wbp] <= 1'b1;
        wbp       <= step(wbp);
      end
      if (rel) begin
        vld[head] <= 1'b0;
        head      <= step(head);
      end
      free_cnt <= free_cnt - CW'(alloc_fire) + CW'(rel) + n_sq;
      wb_pend  <= wb_pend + n_cm - CW'(hs);
    end
  end

  always_ff @(posedge clk) begin
    if (!squash_valid && alloc_fire) begin
      seq_q[tail]  <= alloc_seq;
      size_q[tail] <= '0;
    end
    if (fill_valid && vld[fill_idx]) begin
      addr_q[fill_idx] <= fill_addr;
      size_q[fill_idx] <= fill_size;
      data_q[fill_idx] <= fill_data;
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !squash_valid) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size) && $stable(mem_req_data)));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(SLOTS - 1));

  // R3
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wb_pend) + int'(free_cnt)) <= SLOTS - 1);

  // R8
  drain_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (will_wb && !commit_valid) |=> (wb_pend == $past(wb_pend) - 1'b1));

  // R6
  free_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_valid && !squash_valid && !rel) |=> (free_cnt == $past(free_cnt)));

endmodule

// File: tb/tb_sq_ring.sv
module tb_sq_ring;
  localparam int SLOTS = 4, SEQ_W = 8, ADDR_W = 16, DBYTES = 16;
  localparam int IW = $clog2(SLOTS), CW = IW + 1, SW = $clog2(DBYTES + 1), DW = 8 * DBYTES;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, fill_valid = 0, commit_valid = 0, squash_valid = 0, mem_req_ready = 0;
  logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [IW-1:0] alloc_idx, fill_idx = '0;
  logic [ADDR_W-1:0] fill_addr = '0, mem_req_addr;
  logic [SW-1:0] fill_size = '0, mem_req_size;
  logic [DW-1:0] fill_data = '0, mem_req_data;
  logic full, mem_req_valid, will_wb;
  logic [CW-1:0] free_cnt, wb_pend;

  always #5 clk = ~clk;

  sq_ring #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DBYTES(DBYTES)) dut (.*);

  typedef struct { logic [SEQ_W-1:0] seq; logic [ADDR_W-1:0] a; logic [SW-1:0] s; logic [DW-1:0] d; } st_t;
  st_t held[$];
  st_t expq[$];
  int checks = 0, fails = 0;
  logic [IW-1:0] got_idx;

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [SEQ_W-1:0] s, input logic [IW-1:0] exp_idx, input string r);
    st_t e;
    e.seq = s; e.a = {8'hA0, s}; e.s = SW'(1 + s % DBYTES); e.d = {16{s ^ 8'h5C}};
    chk(r, DW'(alloc_idx), DW'(exp_idx));
    got_idx = alloc_idx;
    alloc_valid = 1; alloc_seq = s; tick; alloc_valid = 0;
    fill_valid = 1; fill_idx = got_idx; fill_addr = e.a; fill_size = e.s; fill_data = e.d;
    tick; fill_valid = 0;
    held.push_back(e);
  endtask

  task automatic commit(input logic [SEQ_W-1:0] c);
    while (held.size() > 0 && held[0].seq < c) expq.push_back(held.pop_front());
    commit_valid = 1; commit_seq = c; tick; commit_valid = 0;
  endtask

  task automatic squash(input logic [SEQ_W-1:0] s);
    while (held.size() > 0 && held[held.size()-1].seq > s) void'(held.pop_back());
    squash_valid = 1; squash_seq = s; tick; squash_valid = 0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) if (rst_n) begin
    // R8
    chk("R8 will_wb", DW'(will_wb), DW'(mem_req_valid && mem_req_ready));
    if (mem_req_valid && mem_req_ready) begin
      if (expq.size() == 0) chk("R3 unexpected write", 1, 0);
      else begin
        st_t e;
        e = expq.pop_front();
        // R4
        chk("R4 addr", DW'(mem_req_addr), DW'(e.a));
        chk("R4 size", DW'(mem_req_size), DW'(e.s));
        chk("R4 data", mem_req_data, e.d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    logic [ADDR_W-1:0] a0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk("R1 free", DW'(free_cnt), DW'(SLOTS - 1));
    chk("R1 full", DW'(full), 0);
    chk("R1 pend", DW'(wb_pend), 0);
    chk("R1 valid", DW'(mem_req_valid), 0);

    put(1, 0, "R2 idx");
    chk("R2 free after one", DW'(free_cnt), DW'(SLOTS - 2));
    put(2, 1, "R2 idx");
    put(3, 2, "R2 idx");
    chk("R2 full", DW'(full), 1);
    chk("R2 free zero", DW'(free_cnt), 0);
    alloc_valid = 1; alloc_seq = 4; tick; alloc_valid = 0;
    chk("R2 ignored alloc free", DW'(free_cnt), 0);
    chk("R2 ignored alloc idx", DW'(alloc_idx), 3);

    commit(3);
    chk("R3 pend", DW'(wb_pend), 2);
    chk("R6 no free on commit", DW'(free_cnt), 0);
    chk("R5 valid", DW'(mem_req_valid), 1);
    a0 = mem_req_addr;
    chk("R4 first addr", DW'(a0), DW'({8'hA0, 8'd1}));
    tick; tick;
    chk("R5 held valid", DW'(mem_req_valid), 1);
    chk("R5 held addr", DW'(mem_req_addr), DW'(a0));
    chk("R8 stalled", DW'(will_wb), 0);

    mem_req_ready = 1;
    for (int i = 0; i < 20 && wb_pend != 0; i++) tick;
    tick; tick;
    mem_req_ready = 0;
    chk("R6 freed after write", DW'(free_cnt), 2);
    chk("R3 uncommitted not sent", DW'(mem_req_valid), 0);
    chk("R3 drained", DW'(expq.size()), 0);

    squash(2);
    chk("R7 free after squash", DW'(free_cnt), 3);
    put(10, 2, "R7 reuse idx");
    put(11, 3, "R9 idx");
    put(12, 0, "R9 wrap idx");
    chk("R2 full again", DW'(full), 1);
    commit(13);
    chk("R3 pend three", DW'(wb_pend), 3);
    for (int i = 0; i < 40 && (wb_pend != 0 || free_cnt != 3); i++) begin
      mem_req_ready = (i % 3 != 0);
      tick;
    end
    mem_req_ready = 0;
    tick;
    chk("R6 all freed", DW'(free_cnt), 3);
    chk("R4 scoreboard empty", DW'(expq.size()), 0);
    chk("R9 next idx", DW'(alloc_idx), 1);
    finish_run;
  end
endmodule